// File: doc/BRIEF.md
# Feed-Sequence Watchdog Timer

This block is a bus-mapped watchdog for a small controller. A fixed divide-by-4 prescaler steps a 32-bit down-counter. Software arms the watchdog with a two-byte feed (0xAA, then 0x55) and must repeat that pair before the counter runs out. If the counter underflows, or if an armed watchdog sees a feed pair broken by any other access, the block raises either a level interrupt request or a one-cycle system-reset request, as the mode bits select.

The block does not generate resets or handle interrupts itself. An external controller turns `rst_req` into a system reset, which comes back on `sys_rst_n`. The time-out flag is cleared only by `por_n`, so after restart software can see that the watchdog caused the reset. Once software sets either enable bit, it cannot clear it again. This keeps a runaway program from switching off a running watchdog.

The register select codes are: 0 = mode, 1 = reload constant, 2 = feed (write only, reads 0), 3 = live count (read only). `acc_rdata` always shows the register chosen by `acc_addr`. It also does so while `acc_en` is low, and a cycle with `acc_en` low is not an access.

Top module: `wdog_feed_guard`

## Requirements
- R1: Once armed, the count decrements once every 4 clocks. After the feed that loads value V, the count reads V for the next 3 clock edges and V-1 after the 4th.
- R2: The reload register resets to 0x000000FF. A write of a value below 0xFF stores 0xFF, and any other value is stored unchanged.
- R3: A feed write of 0xAA (low byte) followed, on the very next access, by a feed write of 0x55 loads the count from the reload register on the edge that samples the 0x55.
- R4: Setting the enable bit alone does not start counting. A completed feed with enable clear loads the count but does not start it. Until the first feed completes with enable set, a broken feed pair raises no request.
- R5: Once armed, any access after a 0xAA feed write other than a 0x55 feed write triggers the watchdog. This includes reads and accesses to other registers. The request becomes visible in the second clock after the bad access.
- R6: Mode register layout: bit 0 is interrupt enable, bit 1 is reset enable, bit 2 is the time-out flag and bit 3 is the interrupt flag. Writing 1 sets bit 0 or bit 1. Writing 0 does not clear them.
- R7: In interrupt mode (bit 0 = 1, bit 1 = 0), with reload value R, underflow occurs 4*(R+1) clocks after the feed. One clock later the interrupt flag and the time-out flag are set and `irq_req` goes high. `irq_req` stays high until a reset.
- R8: In reset mode (bits 0 and 1 both 1), a trigger drives `rst_req` high for exactly one clock and sets the time-out flag. The interrupt flag stays 0.
- R9: A mode write with bit 2 = 0 clears the time-out flag. The time-out flag survives `sys_rst_n` and is cleared by `por_n`. The interrupt flag and the enable bits are cleared by either reset.
- R10: Writes to the count register (select 3) are ignored. A 0x55 feed write that does not follow 0xAA neither loads nor arms the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| sys_rst_n | input | 1 | System reset, active low, spares the time-out flag |
| acc_en | input | 1 | Register access strobe, one access per cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 2 | Register select |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data of the selected register |
| irq_req | output | 1 | Interrupt request level |
| rst_req | output | 1 | System-reset request pulse |

## Verification
The hardest case to reach is the two-clock trigger after a broken feed pair. The watchdog must already be armed, the 0xAA must land, and the very next cycle must carry some other access. The stimulus arms the watchdog with a full pair, writes 0xAA, then issues a mode read or a wrong feed byte on the next clock. It samples the request one and two edges later. The long underflow windows are checked at the exact edge computed from the reload value, with a re-feed placed just before expiry.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    typedef enum logic [1:0] {
        SEL_MODE   = 2'd0,
        SEL_RELOAD = 2'd1,
        SEL_FEED   = 2'd2,
        SEL_COUNT  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        KEY_WAIT_FIRST  = 1'b0,
        KEY_WAIT_SECOND = 1'b1
    } key_state_e;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;
endpackage

// File: rtl/wdg_prescale.sv
module wdg_prescale #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_t;

    pre_t pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        if (restart) begin
            pre_d.cnt = '0;
        end else if (run) begin
            pre_d.cnt = (pre_q.cnt == LAST) ? '0 : pre_q.cnt + 1'b1;
        end
    end

    assign tick = run && !restart && (pre_q.cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q.cnt <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

    // R1: steps are spaced, never back to back
    assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/wdg_feed_track.sv
module wdg_feed_track
    import wdg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_en,
    input  logic       acc_wr,
    input  logic       is_feed,
    input  logic [7:0] wbyte,
    input  logic       armed,
    output logic       feed_ok,
    output logic       feed_bad
);
    typedef struct packed {
        key_state_e st;
        logic       bad;
    } trk_t;

    trk_t trk_d, trk_q;

    logic first_key, second_key;

    assign first_key  = acc_en && acc_wr && is_feed && (wbyte == KEY_FIRST);
    assign second_key = acc_en && acc_wr && is_feed && (wbyte == KEY_SECOND);

    always_comb begin
        trk_d     = trk_q;
        trk_d.bad = 1'b0;
        if (acc_en) begin
            case (trk_q.st)
                KEY_WAIT_FIRST: begin
                    if (first_key) trk_d.st = KEY_WAIT_SECOND;
                end
                KEY_WAIT_SECOND: begin
                    trk_d.st = KEY_WAIT_FIRST;
                    if (!second_key) trk_d.bad = armed;
                end
                default: trk_d.st = KEY_WAIT_FIRST;
            endcase
        end
    end

    assign feed_ok  = (trk_q.st == KEY_WAIT_SECOND) && second_key;
    assign feed_bad = trk_q.bad;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q.st  <= KEY_WAIT_FIRST;
            trk_q.bad <= 1'b0;
        end else begin
            trk_q <= trk_d;
        end
    end

    // R5: a broken pair is only reported once the watchdog is armed
    assert_bad_needs_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        feed_bad |-> $past(armed));
    // R3: whatever follows the first key closes the pair
    assert_pair_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.st == KEY_WAIT_SECOND && acc_en) |=> (trk_q.st == KEY_WAIT_FIRST));
endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown #(
    parameter int              CNT_W   = 32,
    parameter logic [CNT_W-1:0] RST_VAL = CNT_W'(255)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             underflow
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             uf;
    } cd_t;

    cd_t cd_d, cd_q;

    always_comb begin
        cd_d    = cd_q;
        cd_d.uf = 1'b0;
        if (load) begin
            cd_d.cnt = load_val;
        end else if (tick) begin
            if (cd_q.cnt == '0) begin
                cd_d.cnt = load_val;
                cd_d.uf  = 1'b1;
            end else begin
                cd_d.cnt = cd_q.cnt - 1'b1;
            end
        end
    end

    assign count     = cd_q.cnt;
    assign underflow = cd_q.uf;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cd_q.cnt <= RST_VAL;
            cd_q.uf  <= 1'b0;
        end else begin
            cd_q <= cd_d;
        end
    end

    // R1: one step down per prescaler tick
    assert_step_down_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && count != '0) |=> (count == $past(count) - 1'b1));
    // R7: underflow only from an exhausted count
    assert_uf_from_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> ($past(count) == '0));
endmodule

// File: rtl/wdog_feed_guard.sv
module wdog_feed_guard
    import wdg_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int PRE_DIV    = 4,
    parameter int RELOAD_MIN = 255
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             sys_rst_n,
    input  logic             acc_en,
    input  logic             acc_wr,
    input  logic [1:0]       acc_addr,
    input  logic [CNT_W-1:0] acc_wdata,
    output logic [CNT_W-1:0] acc_rdata,
    output logic             irq_req,
    output logic             rst_req
);
    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(RELOAD_MIN);

    typedef struct packed {
        logic             en;
        logic             rsten;
        logic             intf;
        logic             armed;
        logic             rst_pulse;
        logic [CNT_W-1:0] reload;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic tof_d, tof_q;

    logic             rst_all_n;
    reg_sel_e         sel;
    logic             wr_mode, wr_reload;
    logic             feed_ok, feed_bad, tick, underflow, trig;
    logic [CNT_W-1:0] count;

    assign rst_all_n = por_n & sys_rst_n;
    assign sel       = reg_sel_e'(acc_addr);
    assign wr_mode   = acc_en && acc_wr && (sel == SEL_MODE);
    assign wr_reload = acc_en && acc_wr && (sel == SEL_RELOAD);

    wdg_feed_track u_track (
        .clk      (clk),
        .rst_n    (rst_all_n),
        .acc_en   (acc_en),
        .acc_wr   (acc_wr),
        .is_feed  (sel == SEL_FEED),
        .wbyte    (acc_wdata[7:0]),
        .armed    (ctl_q.armed),
        .feed_ok  (feed_ok),
        .feed_bad (feed_bad)
    );

    wdg_prescale #(.DIV(PRE_DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_all_n),
        .run     (ctl_q.armed),
        .restart (feed_ok),
        .tick    (tick)
    );

    wdg_countdown #(.CNT_W(CNT_W), .RST_VAL(FLOOR)) u_cd (
        .clk       (clk),
        .rst_n     (rst_all_n),
        .load      (feed_ok),
        .load_val  (ctl_q.reload),
        .tick      (tick),
        .count     (count),
        .underflow (underflow)
    );

    assign trig = ctl_q.armed && (underflow || feed_bad);

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.rst_pulse = 1'b0;
        if (wr_mode) begin
            ctl_d.en    = ctl_q.en | acc_wdata[0];
            ctl_d.rsten = ctl_q.rsten | acc_wdata[1];
        end
        if (wr_reload) begin
            ctl_d.reload = (acc_wdata < FLOOR) ? FLOOR : acc_wdata;
        end
        if (feed_ok && ctl_q.en) begin
            ctl_d.armed = 1'b1;
        end
        if (trig) begin
            if (ctl_q.rsten) ctl_d.rst_pulse = !ctl_q.rst_pulse;
            else             ctl_d.intf      = 1'b1;
        end
    end

    always_comb begin
        tof_d = tof_q;
        if (wr_mode && !acc_wdata[2]) tof_d = 1'b0;
        if (trig)                     tof_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_all_n) begin
        if (!rst_all_n) begin
            ctl_q.en        <= 1'b0;
            ctl_q.rsten     <= 1'b0;
            ctl_q.intf      <= 1'b0;
            ctl_q.armed     <= 1'b0;
            ctl_q.rst_pulse <= 1'b0;
            ctl_q.reload    <= FLOOR;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) tof_q <= 1'b0;
        else        tof_q <= tof_d;
    end

    always_comb begin
        case (sel)
            SEL_MODE:   acc_rdata = {{(CNT_W-4){1'b0}}, ctl_q.intf, tof_q, ctl_q.rsten, ctl_q.en};
            SEL_RELOAD: acc_rdata = ctl_q.reload;
            SEL_COUNT:  acc_rdata = count;
            default:    acc_rdata = '0;
        endcase
    end

    assign irq_req = ctl_q.intf;
    assign rst_req = ctl_q.rst_pulse;

    // R2: the stored constant never drops below the floor
    assert_reload_floor_R2: assert property (@(posedge clk) disable iff (!rst_all_n)
        ctl_q.reload >= FLOOR);
    // R6: enable bits cannot be cleared without a reset
    assert_en_sticky_R6: assert property (@(posedge clk) disable iff (!rst_all_n)
        ctl_q.en |=> ctl_q.en);
    assert_rsten_sticky_R6: assert property (@(posedge clk) disable iff (!rst_all_n)
        ctl_q.rsten |=> ctl_q.rsten);
    // R5: a broken pair turns into a request one clock later
    assert_bad_to_req_R5: assert property (@(posedge clk) disable iff (!rst_all_n)
        feed_bad |=> (irq_req || rst_req));
    // R7: interrupt request level holds until reset
    assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_all_n)
        irq_req |=> irq_req);
    // R8: reset request is a single-clock pulse
    assert_rst_pulse_R8: assert property (@(posedge clk) disable iff (!rst_all_n)
        rst_req |=> !rst_req);
    // R9: every trigger records the time-out flag
    assert_tof_on_trig_R9: assert property (@(posedge clk) disable iff (!rst_all_n)
        trig |=> tof_q);
    // R4: no counting before arming
    assert_idle_until_armed_R4: assert property (@(posedge clk) disable iff (!rst_all_n)
        !ctl_q.armed |-> !tick);
endmodule

// File: tb/wdog_feed_guard_bench.sv
module wdog_feed_guard_bench;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sys_rst_n = 1'b1;
    logic        acc_en = 1'b0;
    logic        acc_wr = 1'b0;
    logic [1:0]  acc_addr = 2'd0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        irq_req, rst_req;

    int vecs = 0;
    int fails = 0;

    always #2 clk = ~clk;

    wdog_feed_guard u_wdog_feed_guard (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
        .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .irq_req(irq_req), .rst_req(rst_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b0; acc_addr = a;
        #1 d = acc_rdata;
        @(negedge clk);
        acc_en = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [31:0] d);
        acc_addr = a;
        #1 d = acc_rdata;
    endtask

    task automatic feed();
        wr(2'd2, 32'hAA);
        wr(2'd2, 32'h55);
    endtask

    task automatic do_por();
        @(negedge clk);
        por_n = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_por();
        rd(2'd0, v);  chk("R6 mode after reset", v, 32'h0);
        rd(2'd1, v);  chk("R2 reload after reset", v, 32'hFF);
        peek(2'd3, v); chk("R2 count after reset", v, 32'hFF);
        chk("R9 no requests after reset", {30'd0, irq_req, rst_req}, 32'd0);
    endtask

    task automatic t_reload_clamp();
        logic [31:0] v;
        do_por();
        wr(2'd1, 32'h10);       rd(2'd1, v); chk("R2 small value clamped", v, 32'hFF);
        wr(2'd1, 32'h1234);     rd(2'd1, v); chk("R2 large value kept", v, 32'h1234);
        wr(2'd1, 32'hFE);       rd(2'd1, v); chk("R2 0xFE clamped", v, 32'hFF);
        wr(2'd1, 32'hFFFFFFFF); rd(2'd1, v); chk("R2 max kept", v, 32'hFFFFFFFF);
    endtask

    task automatic t_enable_only();
        logic [31:0] v;
        do_por();
        wr(2'd0, 32'h1); wr(2'd0, 32'h0);
        rd(2'd0, v); chk("R6 enable not cleared by 0", v, 32'h1);
        repeat (1100) @(negedge clk);
        peek(2'd3, v); chk("R4 enable alone keeps count", v, 32'hFF);
        chk("R4 no irq without feed", {31'd0, irq_req}, 32'd0);
        wr(2'd2, 32'hAA); rd(2'd0, v);
        repeat (3) @(negedge clk);
        chk("R4 broken pair ignored before arm", {30'd0, irq_req, rst_req}, 32'd0);
        do_por();
        wr(2'd1, 32'h300); feed();
        peek(2'd3, v); chk("R4 feed without enable loads", v, 32'h300);
        repeat (20) @(negedge clk);
        peek(2'd3, v); chk("R4 feed without enable no count", v, 32'h300);
        wr(2'd0, 32'h2); rd(2'd0, v); chk("R6 reset enable bit 1", v, 32'h2);
    endtask

    task automatic t_prescale();
        logic [31:0] v;
        do_por();
        wr(2'd1, 32'h123); wr(2'd0, 32'h1); feed();
        peek(2'd3, v); chk("R3 count loaded", v, 32'h123);
        repeat (3) @(negedge clk);
        peek(2'd3, v); chk("R1 held for 3 clocks", v, 32'h123);
        @(negedge clk);
        peek(2'd3, v); chk("R1 first step", v, 32'h122);
        repeat (4) @(negedge clk);
        peek(2'd3, v); chk("R1 second step", v, 32'h121);
        wr(2'd1, 32'h40); feed();
        peek(2'd3, v); chk("R3 refeed loads clamped reload", v, 32'hFF);
    endtask

    task automatic t_int_timeout();
        logic [31:0] v;
        do_por();
        wr(2'd0, 32'h1); feed();
        repeat (700) @(negedge clk);
        chk("R7 no irq when fed in time", {31'd0, irq_req}, 32'd0);
        feed();
        repeat (1024) @(negedge clk);
        chk("R7 irq not before underflow", {31'd0, irq_req}, 32'd0);
        @(negedge clk);
        chk("R7 irq after underflow", {31'd0, irq_req}, 32'd1);
        chk("R7 no reset request", {31'd0, rst_req}, 32'd0);
        rd(2'd0, v); chk("R7 flags set", v, 32'hD);
        repeat (10) @(negedge clk);
        chk("R7 irq level held", {31'd0, irq_req}, 32'd1);
        wr(2'd0, 32'h0); rd(2'd0, v); chk("R9 tof cleared by software", v, 32'h9);
    endtask

    task automatic t_reset_mode();
        logic [31:0] v;
        do_por();
        wr(2'd0, 32'h3); feed();
        repeat (1024) @(negedge clk);
        chk("R8 no pulse early", {31'd0, rst_req}, 32'd0);
        @(negedge clk);
        chk("R8 pulse high", {31'd0, rst_req}, 32'd1);
        @(negedge clk);
        chk("R8 pulse one clock", {31'd0, rst_req}, 32'd0);
        chk("R8 no irq in reset mode", {31'd0, irq_req}, 32'd0);
        rd(2'd0, v); chk("R8 tof set intf clear", v, 32'h7);
        @(negedge clk); sys_rst_n = 1'b0;
        @(negedge clk); sys_rst_n = 1'b1;
        rd(2'd0, v); chk("R9 tof survives system reset", v, 32'h4);
        do_por();
        rd(2'd0, v); chk("R9 power-on clears tof", v, 32'h0);
    endtask

    task automatic t_bad_feed();
        logic [31:0] v;
        do_por();
        wr(2'd0, 32'h1); feed();
        repeat (2) @(negedge clk);
        chk("R5 good pair no trigger", {31'd0, irq_req}, 32'd0);
        wr(2'd2, 32'hAA); rd(2'd0, v);
        chk("R5 not in first clock", {31'd0, irq_req}, 32'd0);
        @(negedge clk);
        chk("R5 irq in second clock after read", {31'd0, irq_req}, 32'd1);
        do_por();
        wr(2'd0, 32'h3); feed();
        wr(2'd2, 32'hAA); wr(2'd2, 32'h56);
        chk("R5 reset not in first clock", {31'd0, rst_req}, 32'd0);
        @(negedge clk);
        chk("R5 reset in second clock after bad byte", {31'd0, rst_req}, 32'd1);
        do_por();
        wr(2'd0, 32'h1); feed();
        wr(2'd2, 32'hAA); wr(2'd1, 32'h500);
        @(negedge clk);
        chk("R5 other-register write breaks pair", {31'd0, irq_req}, 32'd1);
    endtask

    task automatic t_count_ro();
        logic [31:0] v;
        do_por();
        wr(2'd3, 32'h5555);
        peek(2'd3, v); chk("R10 count write ignored", v, 32'hFF);
        wr(2'd1, 32'h400); wr(2'd0, 32'h1); wr(2'd2, 32'h55);
        repeat (20) @(negedge clk);
        peek(2'd3, v); chk("R10 lone second key ignored", v, 32'hFF);
    endtask

    initial begin
        t_reset();
        t_reload_clamp();
        t_enable_only();
        t_prescale();
        t_int_timeout();
        t_reset_mode();
        t_bad_feed();
        t_count_ro();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule